// File: doc/BRIEF.md
# Receive Character Queue with Per-Entry Error Tags

This block buffers characters coming out of a serial deserializer until a host collects them. Every stored entry pairs a data byte with three error flags that were captured together with it. When the head entry leaves the queue, the flags go with it, so the status seen by the host always belongs to the byte currently offered. The head entry is presented continuously as a holding register, and a single-cycle host read strobe removes it.

Two interrupt sources are derived from the fill level. The data-ready interrupt fires either as soon as anything is stored or only once a selectable threshold is met. A timeout interrupt makes sure a few characters stranded below that threshold still reach the host. This happens after a quiet period of four character times plus twelve bit times, where the character time depends on the configured word length. With queueing switched off, the block acts as a single-character holding register.

Top module: `rxq_tagged_fifo`

## Requirements
- R1: After reset the queue is empty: `level` is 0, `data_avail`, `overrun`, `rdy_irq` and `tmo_irq` are all 0.
- R2: With `fifo_en`=1 up to 64 entries are held in arrival order, and `level` gives the number stored. Each entry is `wr_data` and `wr_flags` taken together in the cycle `wr_valid` is high.
- R3: An entry is removed only by `rd_pop` while `level`>0. From the cycle after the pop, `head_data` and `head_flags` show the data and flags of the next entry, and `data_avail` is high exactly when `level`>0.
- R4: A write and a pop in the same cycle on a full queue both take effect: the head is removed, the new entry is appended, and `level` stays at 64.
- R5: A write while the queue is at capacity without a pop in the same cycle discards the character and sets `overrun`. `overrun` stays set until a pop removes an entry, and a new overflow takes priority over that clear.
- R6: With `fifo_en`=0 the capacity is one entry. Any change of `fifo_en` empties the queue in the cycle it is seen, and a write or pop in that cycle is ignored.
- R7: `rdy_irq` (when `int_en`=1) is high when `level`>0 if `rdy_mode`=0 or `fifo_en`=0. If `rdy_mode`=1 and `fifo_en`=1 it is high when `level` is at least the threshold picked by `trig_sel`: 0→8, 1→16, 2→56, 3→60.
- R8: With `fifo_en`=1 and 0<`level`<threshold, `bit_tick` pulses are counted while no `wr_valid` or `rd_pop` occurs. `tmo_irq` (when `int_en`=1) rises in the cycle after pulse number 4×(`word_len`+7)+12, i.e. 40, 44, 48 or 52. It is cleared and the count restarts on any `wr_valid` or `rd_pop`, or when the level leaves that window.
- R9: With `int_en`=0 both `rdy_irq` and `tmo_irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Character strobe from the deserializer |
| wr_data | input | 8 | Received data byte |
| wr_flags | input | 3 | Error flags for the byte |
| rd_pop | input | 1 | Host read of the holding register |
| fifo_en | input | 1 | 1: 64-entry queue, 0: single holding register |
| rdy_mode | input | 1 | 0: ready on any data, 1: ready at threshold |
| trig_sel | input | 2 | Threshold select |
| word_len | input | 2 | Word-length code, sets the character time |
| bit_tick | input | 1 | One pulse per serial bit time |
| int_en | input | 1 | Receive interrupt enable |
| head_data | output | 8 | Data byte of the head entry |
| head_flags | output | 3 | Error flags of the head entry |
| data_avail | output | 1 | Queue holds at least one entry |
| level | output | 7 | Number of stored entries |
| overrun | output | 1 | A character was lost to a full queue |
| rdy_irq | output | 1 | Data-ready interrupt |
| tmo_irq | output | 1 | Timeout interrupt |

## Verification
A deserializer write and a host pop can land in the same cycle. This matters most when the queue is full and the pop has to make room for the write, and when the queue is empty and the pop has nothing to remove. Both cases are forced by directed sequences that fill the queue to 64 and keep writing and popping together, then drain it completely. After that, random traffic with writes and pops drawn independently every cycle produces many more collisions. The resulting level, head entry, overrun flag and timeout restart are judged each cycle against a bench model of the queue.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int DATA_W = 8;
  localparam int FLAG_W = 3;

  typedef struct packed {
    logic [FLAG_W-1:0] flags;
    logic [DATA_W-1:0] data;
  } rxq_ent_t;

  localparam int ENT_W = $bits(rxq_ent_t);
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          wr_en,
  input  rxq_ent_t      wr_ent,
  input  logic          rd_pop,
  output rxq_ent_t      head_ent,
  output logic [CW-1:0] count,
  output logic          overrun,
  output logic          flush
);
  localparam int AW = $clog2(DEPTH);

  rxq_ent_t       mem [DEPTH];
  logic [AW-1:0]  wptr_q, wptr_n, rptr_q, rptr_n;
  logic [CW-1:0]  cnt_q, cnt_n, cap;
  logic           ovr_q, ovr_n, fen_q;
  logic           do_pop, do_push, room, ovf;

  assign flush = (fen_q != fifo_en);
  assign cap   = fifo_en ? CW'(DEPTH) : CW'(1);

  always_comb begin
    do_pop  = rd_pop && (cnt_q != '0) && !flush;
    room    = (cnt_q < cap) || do_pop;
    do_push = wr_en && room && !flush;
    ovf     = wr_en && !room && !flush;

    wptr_n = wptr_q;
    rptr_n = rptr_q;
    cnt_n  = cnt_q;
    if (flush) begin
      wptr_n = '0;
      rptr_n = '0;
      cnt_n  = '0;
    end else begin
      if (do_push) wptr_n = (wptr_q == AW'(DEPTH-1)) ? '0 : wptr_q + 1'b1;
      if (do_pop)  rptr_n = (rptr_q == AW'(DEPTH-1)) ? '0 : rptr_q + 1'b1;
      cnt_n = cnt_q + {{(CW-1){1'b0}}, do_push} - {{(CW-1){1'b0}}, do_pop};
    end

    if (ovf)         ovr_n = 1'b1;
    else if (do_pop) ovr_n = 1'b0;
    else             ovr_n = ovr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      ovr_q  <= 1'b0;
      fen_q  <= 1'b0;
    end else begin
      wptr_q <= wptr_n;
      rptr_q <= rptr_n;
      cnt_q  <= cnt_n;
      ovr_q  <= ovr_n;
      fen_q  <= fifo_en;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr_q] <= wr_ent;
  end

  assign head_ent = mem[rptr_q];
  assign count    = cnt_q;
  assign overrun  = ovr_q;

  // R2: never more than DEPTH entries
  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  // R5: write into a full queue without pop raises overrun
  p_ovr_on_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_pop && !flush && cnt_q == cap) |=> ovr_q);

  // R3: a lone pop lowers the level by one
  p_pop_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pop && !wr_en && !flush && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

  // R6: single-entry capacity when queueing is off
  p_single_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && !fen_q) |-> cnt_q <= CW'(1));
endmodule

// File: rtl/rxq_timer.sv
module rxq_timer #(
  parameter int TMO_CHARS = 4,
  parameter int TMO_EXTRA = 12,
  parameter int CHAR_BASE = 7,
  parameter int TW = $clog2(TMO_CHARS*(CHAR_BASE+3)+TMO_EXTRA+1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flush,
  input  logic       activity,
  input  logic       in_win,
  input  logic       bit_tick,
  input  logic [1:0] word_len,
  output logic       hit
);
  logic [TW-1:0] cnt_q, cnt_n, lim;
  logic          hit_q, hit_n, step_en;

  assign lim     = TW'(TMO_CHARS*(CHAR_BASE + int'(word_len)) + TMO_EXTRA);
  assign step_en = bit_tick && !hit_q;

  always_comb begin
    cnt_n = cnt_q;
    hit_n = hit_q;
    if (flush || activity || !in_win) begin
      cnt_n = '0;
      hit_n = 1'b0;
    end else if (step_en) begin
      cnt_n = cnt_q + 1'b1;
      if (cnt_q + 1'b1 >= lim) hit_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      hit_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      hit_q <= hit_n;
    end
  end

  assign hit = hit_q;

  // R8: timeout only rises from a counted tick inside the window
  p_tmo_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hit_q) |-> $past(in_win && bit_tick && !activity));

  // R8: any write or pop clears a pending timeout
  p_tmo_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    activity |=> !hit_q);
endmodule

// File: rtl/rxq_irq.sv
module rxq_irq #(
  parameter int CW    = 7,
  parameter int TRIG0 = 8,
  parameter int TRIG1 = 16,
  parameter int TRIG2 = 56,
  parameter int TRIG3 = 60
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  logic          fifo_en,
  input  logic          rdy_mode,
  input  logic [1:0]    trig_sel,
  input  logic          int_en,
  input  logic          hit,
  output logic          in_win,
  output logic          rdy_irq,
  output logic          tmo_irq
);
  localparam int NTRIG = 4;
  localparam logic [CW-1:0] TRIG_TAB [NTRIG] =
    '{CW'(TRIG0), CW'(TRIG1), CW'(TRIG2), CW'(TRIG3)};

  logic [CW-1:0] thr;
  logic          nonempty, at_thr, ready_raw;

  always_comb begin
    thr = TRIG_TAB[0];
    for (int i = 1; i < NTRIG; i++)
      if (trig_sel == 2'(i)) thr = TRIG_TAB[i];
  end

  assign nonempty  = (count != '0);
  assign at_thr    = (count >= thr);
  assign in_win    = fifo_en && nonempty && !at_thr;
  assign ready_raw = (fifo_en && rdy_mode) ? at_thr : nonempty;
  assign rdy_irq   = int_en && nonempty && ready_raw;
  assign tmo_irq   = int_en && hit;

  // R7: data-ready never signals an empty queue
  p_rdy_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_irq |-> count != '0);
endmodule

// File: rtl/rxq_tagged_fifo.sv
module rxq_tagged_fifo
  import rxq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int TRIG0 = 8,
  parameter int TRIG1 = 16,
  parameter int TRIG2 = 56,
  parameter int TRIG3 = 60,
  parameter int LW    = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [FLAG_W-1:0] wr_flags,
  input  logic              rd_pop,
  input  logic              fifo_en,
  input  logic              rdy_mode,
  input  logic [1:0]        trig_sel,
  input  logic [1:0]        word_len,
  input  logic              bit_tick,
  input  logic              int_en,
  output logic [DATA_W-1:0] head_data,
  output logic [FLAG_W-1:0] head_flags,
  output logic              data_avail,
  output logic [LW-1:0]     level,
  output logic              overrun,
  output logic              rdy_irq,
  output logic              tmo_irq
);
  logic [1:0]    rst_sync;
  logic          rst_s_n;
  rxq_ent_t      wr_ent, head_ent;
  logic [LW-1:0] count;
  logic          flush, in_win, hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s_n = rst_sync[1];

  assign wr_ent.data  = wr_data;
  assign wr_ent.flags = wr_flags;

  rxq_store #(.DEPTH(DEPTH), .CW(LW)) u_store (
    .clk(clk), .rst_n(rst_s_n), .fifo_en(fifo_en), .wr_en(wr_valid),
    .wr_ent(wr_ent), .rd_pop(rd_pop), .head_ent(head_ent),
    .count(count), .overrun(overrun), .flush(flush)
  );

  rxq_timer u_timer (
    .clk(clk), .rst_n(rst_s_n), .flush(flush), .activity(wr_valid || rd_pop),
    .in_win(in_win), .bit_tick(bit_tick), .word_len(word_len), .hit(hit)
  );

  rxq_irq #(.CW(LW), .TRIG0(TRIG0), .TRIG1(TRIG1), .TRIG2(TRIG2), .TRIG3(TRIG3)) u_irq (
    .clk(clk), .rst_n(rst_s_n), .count(count), .fifo_en(fifo_en),
    .rdy_mode(rdy_mode), .trig_sel(trig_sel), .int_en(int_en), .hit(hit),
    .in_win(in_win), .rdy_irq(rdy_irq), .tmo_irq(tmo_irq)
  );

  assign head_data  = head_ent.data;
  assign head_flags = head_ent.flags;
  assign level      = count;
  assign data_avail = (count != '0);

  // R9: disabled interrupts stay quiet
  p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    !int_en |-> !(rdy_irq || tmo_irq));
endmodule

// File: tb/test_rxq_tagged_fifo.sv
module test_rxq_tagged_fifo;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_valid, rd_pop, fifo_en, rdy_mode, bit_tick, int_en;
  logic [7:0] wr_data;
  logic [2:0] wr_flags;
  logic [1:0] trig_sel, word_len;
  logic [7:0] head_data;
  logic [2:0] head_flags;
  logic       data_avail, overrun, rdy_irq, tmo_irq;
  logic [6:0] level;

  int tests = 0, fails = 0, cyc = 0;

  logic [10:0] q[$];
  bit   m_fen_prev = 0, m_ovr = 0, m_hit = 0;
  int   m_tcnt = 0;

  always #4 clk = ~clk;

  rxq_tagged_fifo i_rxq_tagged_fifo (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_flags(wr_flags), .rd_pop(rd_pop), .fifo_en(fifo_en), .rdy_mode(rdy_mode),
    .trig_sel(trig_sel), .word_len(word_len), .bit_tick(bit_tick), .int_en(int_en),
    .head_data(head_data), .head_flags(head_flags), .data_avail(data_avail),
    .level(level), .overrun(overrun), .rdy_irq(rdy_irq), .tmo_irq(tmo_irq)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired after %0d cycles (exp finish)", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  function automatic int thr_of(logic [1:0] s);
    case (s)
      2'd0: return 8;
      2'd1: return 16;
      2'd2: return 56;
      default: return 60;
    endcase
  endfunction

  function automatic int tmo_lim(logic [1:0] wl);
    return 4 * (int'(wl) + 7) + 12;
  endfunction

  function automatic bit exp_rdy();
    if (!int_en || q.size() == 0) return 0;
    if (fifo_en && rdy_mode) return q.size() >= thr_of(trig_sel);
    return 1;
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model(bit wr, logic [10:0] ent, bit pop, bit tick);
    int  cap;
    bit  dpop, room, win;
    cap = fifo_en ? 64 : 1;
    win = fifo_en && q.size() > 0 && q.size() < thr_of(trig_sel);
    if (fifo_en != m_fen_prev) begin
      q.delete();
      m_tcnt = 0;
      m_hit  = 0;
    end else begin
      dpop = pop && q.size() > 0;
      room = q.size() < cap || dpop;
      if (wr && !room) m_ovr = 1;
      else if (dpop)   m_ovr = 0;
      if (dpop) void'(q.pop_front());
      if (wr && room) q.push_back(ent);
      if (wr || pop || !win) begin
        m_tcnt = 0;
        m_hit  = 0;
      end else if (tick && !m_hit) begin
        m_tcnt++;
        if (m_tcnt >= tmo_lim(word_len)) m_hit = 1;
      end
    end
    m_fen_prev = fifo_en;
  endtask

  task automatic step(bit wr, logic [7:0] d, logic [2:0] f, bit pop, bit tick);
    bit    full_both;
    string lt;
    full_both = wr && pop && fifo_en && q.size() == 64 && fifo_en == m_fen_prev;
    wr_valid = wr; wr_data = d; wr_flags = f; rd_pop = pop; bit_tick = tick;
    @(posedge clk);
    model(wr, {f, d}, pop, tick);
    @(negedge clk);
    wr_valid = 0; rd_pop = 0; bit_tick = 0;
    lt = full_both ? "R4" : (!fifo_en ? "R6" : "R2");
    check(lt, level, q.size(), "level");
    check("R3", data_avail, q.size() > 0, "data_avail");
    if (q.size() > 0) begin
      check("R3", head_data, q[0][7:0], "head_data");
      check("R3", head_flags, q[0][10:8], "head_flags");
    end
    check("R5", overrun, m_ovr, "overrun");
    check(int_en ? "R7" : "R9", rdy_irq, exp_rdy(), "rdy_irq");
    check(int_en ? "R8" : "R9", tmo_irq, int_en && m_hit, "tmo_irq");
  endtask

  task automatic push_n(int n);
    for (int i = 0; i < n; i++) step(1, 8'($urandom), 3'($urandom), 0, 0);
  endtask

  task automatic pop_n(int n);
    for (int i = 0; i < n; i++) step(0, 8'h00, 3'd0, 1, 0);
  endtask

  task automatic tick_n(int n);
    for (int i = 0; i < n; i++) step(0, 8'h00, 3'd0, 0, 1);
  endtask

  initial begin
    void'($urandom(32'h1c3a_5e7d));
    rst_n = 0; wr_valid = 0; rd_pop = 0; bit_tick = 0; wr_data = 0; wr_flags = 0;
    fifo_en = 0; rdy_mode = 0; trig_sel = 0; word_len = 0; int_en = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", level, 0, "level");
    check("R1", data_avail, 0, "data_avail");
    check("R1", overrun, 0, "overrun");
    check("R1", rdy_irq, 0, "rdy_irq");
    check("R1", tmo_irq, 0, "tmo_irq");

    // R8: timeout at 40 ticks for word_len 0, then cleared by a pop
    fifo_en = 1; int_en = 1; rdy_mode = 1; trig_sel = 0; word_len = 0;
    step(0, 0, 0, 0, 0);
    push_n(5);
    tick_n(45);
    pop_n(1);
    word_len = 3;
    tick_n(55);
    push_n(1);
    tick_n(10);

    // R2, R5, R4: fill past capacity, collide at full, drain
    push_n(62);
    push_n(2);
    for (int i = 0; i < 4; i++) step(1, 8'($urandom), 3'($urandom), 1, 0);
    pop_n(1);
    pop_n(66);
    step(1, 8'h5a, 3'd5, 1, 0);  // pop on empty with write

    // R7: high threshold
    trig_sel = 3;
    push_n(61);
    trig_sel = 2;
    pop_n(10);
    pop_n(52);

    // R9: interrupts masked while data and timeout exist
    int_en = 0; trig_sel = 1; word_len = 1;
    push_n(3);
    tick_n(50);
    int_en = 1;
    tick_n(1);
    rdy_mode = 0;
    pop_n(3);

    // R6: single holding register, overflow, mode change flush
    fifo_en = 0;
    push_n(1);
    push_n(1);
    push_n(1);
    pop_n(1);
    push_n(1);
    fifo_en = 1;
    push_n(1);
    pop_n(2);

    // random traffic
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 199) == 0) trig_sel = 2'($urandom);
      if ($urandom_range(0, 199) == 0) word_len = 2'($urandom);
      if ($urandom_range(0, 299) == 0) rdy_mode = ~rdy_mode;
      if ($urandom_range(0, 299) == 0) int_en = ~int_en;
      if ($urandom_range(0, 999) == 0) fifo_en = ~fifo_en;
      if ((i / 1000) % 2 == 0)
        step($urandom_range(0, 1) == 0, 8'($urandom), 3'($urandom),
             $urandom_range(0, 3) == 0, $urandom_range(0, 1) == 0);
      else
        step($urandom_range(0, 19) == 0, 8'($urandom), 3'($urandom),
             $urandom_range(0, 24) == 0, 1'b1);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule